// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block keeps the exception state of a small multicycle processor and decides, at each instruction boundary, whether execution leaves the normal flow for a handler. Four event sources feed it. An arithmetic overflow flag comes from the execute step. An undefined-instruction flag comes from decode. A system-call instruction is recognised in the instruction register. An external interrupt request arrives as a level. Each source has an enable bit in a Status register. When an enabled event is taken, the unit saves the return address in EPC, writes a 2-bit code into Cause, and shifts Status left by four. In the same cycle it tells the processor to load a fixed handler address.

The unit also decodes return-from-exception, which reloads the PC from EPC and shifts Status back right by four. It decodes the two transfer instructions that move data between a general register and its own registers. The processor's control FSM supplies the instruction word, the end-of-instruction strobe, the address of the next instruction and the general-register operand. It obeys the PC load request that comes back.

Top module: `cp0_exc_unit`

## Requirements
- R1: After reset, Status reads 0x0000000F, Cause reads 0 and EPC reads 0, and neither `pc_load_o` nor `iack_o` is asserted.
- R2: When an enabled event is taken at a boundary, `pc_load_o` is 1 and `pc_target_o` is 0x00000004 in that same cycle. After the clock edge, EPC holds `pc_i`, Status holds its former value shifted left by 4 with zeros filled in, and Cause holds the event code.
- R3: The Cause codes are 0 for external interrupt, 1 for undefined instruction, 2 for overflow and 3 for system call. A system call is an instruction with bits 31:26 = 000000 and bits 5:0 = 001100.
- R4: The Status enable bits are bit 3 for interrupt, bit 2 for undefined instruction, bit 1 for overflow and bit 0 for system call. An event whose bit is 0 causes no redirect and no acknowledge, and leaves EPC and Cause unchanged.
- R5: When several enabled events are present at one boundary, exactly one is taken. The order is overflow first, then undefined instruction, then system call, then interrupt. A higher event that is disabled lets the next enabled one through.
- R6: Events act only in a cycle where `instr_end_i` is 1, so no redirect happens in any other cycle. An overflow flagged in an earlier cycle of the same instruction is still taken at that instruction's boundary.
- R7: A raised `irq_i` waits for the next boundary. `iack_o` is a single-cycle pulse, given only in the cycle an interrupt is taken, and it is never given for the other event types.
- R8: Return-from-exception (bits 31:26 = 010000, bit 25 = 1, bits 5:0 = 010000) at a boundary asserts `pc_load_o` with `pc_target_o` equal to EPC, and shifts Status right by 4 with zeros filled in.
- R9: A boundary that completes a return-from-exception takes no event. A pending interrupt is taken at a later boundary.
- R10: Move-to (bits 31:26 = 010000, bits 25:21 = 00100, bits 10:0 = 0) at a boundary writes `gpr_wdata_i` into the register selected by bits 15:11: 12 for Status, 13 for Cause, 14 for EPC. Cause keeps only bits 1:0. Writes to any other number are dropped.
- R11: `cp0_rdata_o` shows the register selected by instruction bits 15:11, with Cause zero-extended. Any number other than 12, 13 or 14 reads 0.
- R12: If an event is taken at the same boundary as a move-to, the event wins and the move-to write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction register contents |
| instr_end_i | input | 1 | High in the last cycle of each instruction |
| pc_i | input | 32 | Address of the following instruction |
| ovf_i | input | 1 | Arithmetic overflow from the execute step |
| undef_i | input | 1 | Undefined instruction detected |
| irq_i | input | 1 | External interrupt request, level |
| gpr_wdata_i | input | 32 | General register value for move-to |
| cp0_rdata_o | output | 32 | Selected register value for move-from |
| pc_load_o | output | 1 | Processor must load `pc_target_o` |
| pc_target_o | output | 32 | Handler address or return address |
| iack_o | output | 1 | Interrupt acknowledge pulse |

## Verification
The redirect request, its target and the acknowledge are combinational. They are due in the boundary cycle itself. The bench drives each boundary just after a falling edge and samples these outputs one time unit later, before the rising edge. EPC, Cause and Status change at the rising edge that ends the boundary cycle. The bench reads them through the move-from port after that edge, with the strobe low so that the read cannot disturb any state. Cycles that are not boundaries are sampled in the same way, to show that no redirect or acknowledge appears there.

// File: rtl/cp0_pkg.sv
package cp0_pkg;

  typedef enum logic [1:0] {
    EV_EXTIRQ = 2'd0,
    EV_BADOP  = 2'd1,
    EV_OVF    = 2'd2,
    EV_SYSC   = 2'd3
  } cause_t;

  localparam int unsigned NUM_EV = 4;
  localparam int unsigned SEL_W  = 5;

  localparam logic [SEL_W-1:0] SEL_STATUS = 5'd12;
  localparam logic [SEL_W-1:0] SEL_CAUSE  = 5'd13;
  localparam logic [SEL_W-1:0] SEL_EPC    = 5'd14;

  typedef struct packed {
    logic             is_mtc;
    logic             is_rfe;
    logic             is_sysc;
    logic [SEL_W-1:0] sel;
  } cp0_dec_t;

  // Status enable bit that gates each event code.
  function automatic int unsigned mask_bit(cause_t c);
    case (c)
      EV_EXTIRQ: mask_bit = 3;
      EV_BADOP:  mask_bit = 2;
      EV_OVF:    mask_bit = 1;
      default:   mask_bit = 0;
    endcase
  endfunction

  // Rank 0 is the most urgent.
  function automatic cause_t prio_code(int unsigned rank);
    case (rank)
      0:       prio_code = EV_OVF;
      1:       prio_code = EV_BADOP;
      2:       prio_code = EV_SYSC;
      default: prio_code = EV_EXTIRQ;
    endcase
  endfunction

  function automatic logic [31:0] nest_push(logic [31:0] s, int unsigned sh);
    nest_push = s << sh;
  endfunction

  function automatic logic [31:0] nest_pop(logic [31:0] s, int unsigned sh);
    nest_pop = s >> sh;
  endfunction

endpackage

// File: rtl/cp0_decode.sv
module cp0_decode
  import cp0_pkg::*;
#(
  parameter int unsigned INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr_i,
  output cp0_dec_t           dec_o
);
  localparam logic [5:0] OP_COP   = 6'b010000;
  localparam logic [5:0] OP_SPEC  = 6'b000000;
  localparam logic [5:0] FN_SYSC  = 6'b001100;
  localparam logic [5:0] FN_RFE   = 6'b010000;
  localparam logic [4:0] SUB_MTC  = 5'b00100;

  logic [5:0] opc, fn;
  logic [4:0] sub;
  logic       unused_rt;

  assign opc       = instr_i[31:26];
  assign sub       = instr_i[25:21];
  assign fn        = instr_i[5:0];
  assign unused_rt = ^instr_i[20:16];

  always_comb begin
    dec_o         = '0;
    dec_o.sel     = instr_i[15:11];
    dec_o.is_mtc  = (opc == OP_COP) && (sub == SUB_MTC) && (instr_i[10:0] == 11'd0);
    dec_o.is_rfe  = (opc == OP_COP) && instr_i[25] && (fn == FN_RFE);
    dec_o.is_sysc = (opc == OP_SPEC) && (fn == FN_SYSC);
  end
endmodule

// File: rtl/cp0_evt_arb.sv
module cp0_evt_arb
  import cp0_pkg::*;
#(
  parameter int unsigned MASK_W = 32
) (
  input  logic [NUM_EV-1:0] raw_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              arm_i,
  output logic              take_o,
  output cause_t            code_o
);
  logic [NUM_EV-1:0] en;

  generate
    for (genvar c = 0; c < NUM_EV; c++) begin : g_gate
      assign en[c] = raw_i[c] & mask_i[mask_bit(cause_t'(c))];
    end
  endgenerate

  always_comb begin
    code_o = EV_EXTIRQ;
    for (int r = NUM_EV - 1; r >= 0; r--) begin
      if (en[prio_code(r)]) code_o = prio_code(r);
    end
  end

  assign take_o = arm_i & (|en);
endmodule

// File: rtl/cp0_regs.sv
module cp0_regs
  import cp0_pkg::*;
#(
  parameter int unsigned     DATA_W     = 32,
  parameter int unsigned     NEST_SHIFT = 4,
  parameter logic [DATA_W-1:0] RST_STATUS = 32'h0000_000F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  cause_t            code_i,
  input  logic [DATA_W-1:0] epc_in_i,
  input  logic              leave_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] epc_o,
  output logic [1:0]        cause_o
);
  logic [DATA_W-1:0] status_q, epc_q;
  logic [1:0]        cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= RST_STATUS;
      epc_q    <= '0;
      cause_q  <= '0;
    end else if (take_i) begin
      epc_q    <= epc_in_i;
      cause_q  <= code_i;
      status_q <= nest_push(status_q, NEST_SHIFT);
    end else if (leave_i) begin
      status_q <= nest_pop(status_q, NEST_SHIFT);
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_STATUS: status_q <= wr_data_i;
        SEL_CAUSE:  cause_q  <= wr_data_i[1:0];
        SEL_EPC:    epc_q    <= wr_data_i;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (rd_sel_i)
      SEL_STATUS: rd_data_o = status_q;
      SEL_CAUSE:  rd_data_o = {{(DATA_W-2){1'b0}}, cause_q};
      SEL_EPC:    rd_data_o = epc_q;
      default:    rd_data_o = '0;
    endcase
  end

  assign status_o = status_q;
  assign epc_o    = epc_q;
  assign cause_o  = cause_q;
endmodule

// File: rtl/cp0_exc_unit.sv
module cp0_exc_unit
  import cp0_pkg::*;
#(
  parameter int unsigned       DATA_W       = 32,
  parameter int unsigned       NEST_SHIFT   = 4,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 32'h0000_0004,
  parameter logic [DATA_W-1:0] RST_STATUS   = 32'h0000_000F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       instr_i,
  input  logic              instr_end_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic              ovf_i,
  input  logic              undef_i,
  input  logic              irq_i,
  input  logic [DATA_W-1:0] gpr_wdata_i,
  output logic [DATA_W-1:0] cp0_rdata_o,
  output logic              pc_load_o,
  output logic [DATA_W-1:0] pc_target_o,
  output logic              iack_o
);
  cp0_dec_t          dec;
  logic              ovf_seen_q;
  logic [NUM_EV-1:0] raw_evt;
  logic              arm_w, take_w, rfe_w, wr_w;
  cause_t            code_w;
  logic [DATA_W-1:0] status_q, epc_q;
  logic [1:0]        cause_q;

  cp0_decode #(.INSTR_W(32)) u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  // Overflow may be flagged before the boundary; hold it until then.
  always_ff @(posedge clk) begin
    if (!rst_n)           ovf_seen_q <= 1'b0;
    else if (instr_end_i) ovf_seen_q <= 1'b0;
    else if (ovf_i)       ovf_seen_q <= 1'b1;
  end

  always_comb begin
    raw_evt            = '0;
    raw_evt[EV_OVF]    = ovf_i | ovf_seen_q;
    raw_evt[EV_BADOP]  = undef_i;
    raw_evt[EV_SYSC]   = dec.is_sysc;
    raw_evt[EV_EXTIRQ] = irq_i;
  end

  assign arm_w = instr_end_i & ~dec.is_rfe;
  assign rfe_w = instr_end_i & dec.is_rfe;

  cp0_evt_arb #(.MASK_W(DATA_W)) u_arb (
    .raw_i  (raw_evt),
    .mask_i (status_q),
    .arm_i  (arm_w),
    .take_o (take_w),
    .code_o (code_w)
  );

  assign wr_w = instr_end_i & dec.is_mtc & ~take_w;

  cp0_regs #(
    .DATA_W     (DATA_W),
    .NEST_SHIFT (NEST_SHIFT),
    .RST_STATUS (RST_STATUS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take_w),
    .code_i    (code_w),
    .epc_in_i  (pc_i),
    .leave_i   (rfe_w),
    .wr_en_i   (wr_w),
    .wr_sel_i  (dec.sel),
    .wr_data_i (gpr_wdata_i),
    .rd_sel_i  (dec.sel),
    .rd_data_o (cp0_rdata_o),
    .status_o  (status_q),
    .epc_o     (epc_q),
    .cause_o   (cause_q)
  );

  assign pc_load_o   = take_w | rfe_w;
  assign pc_target_o = take_w ? HANDLER_ADDR : epc_q;
  assign iack_o      = take_w & (code_w == EV_EXTIRQ);
endmodule

// File: rtl/cp0_exc_chk.sv
module cp0_exc_chk
  import cp0_pkg::*;
#(
  parameter int unsigned       DATA_W       = 32,
  parameter int unsigned       NEST_SHIFT   = 4,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 32'h0000_0004
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_end_i,
  input logic              irq_i,
  input logic [DATA_W-1:0] pc_i,
  input logic              pc_load_o,
  input logic [DATA_W-1:0] pc_target_o,
  input logic              iack_o,
  input logic              take_w,
  input logic              rfe_w,
  input cause_t            code_w,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] epc_q,
  input logic [1:0]        cause_q
);
  p_no_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_end_i |-> !pc_load_o);

  p_handler_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |-> (pc_load_o && pc_target_o == HANDLER_ADDR));

  p_epc_save_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> (epc_q == $past(pc_i)));

  p_status_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> (status_q == ($past(status_q) << NEST_SHIFT)));

  p_cause_rec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> (cause_q == $past(code_w)));

  p_enabled_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |-> status_q[mask_bit(code_w)]);

  p_iack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |=> !iack_o);

  p_iack_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |-> (irq_i && instr_end_i));

  p_rfe_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rfe_w |-> (pc_load_o && pc_target_o == epc_q));

  p_rfe_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rfe_w |=> (status_q == ($past(status_q) >> NEST_SHIFT)));

  p_rfe_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rfe_w |-> !iack_o);
endmodule

bind cp0_exc_unit cp0_exc_chk #(
  .DATA_W       (DATA_W),
  .NEST_SHIFT   (NEST_SHIFT),
  .HANDLER_ADDR (HANDLER_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_end_i (instr_end_i),
  .irq_i       (irq_i),
  .pc_i        (pc_i),
  .pc_load_o   (pc_load_o),
  .pc_target_o (pc_target_o),
  .iack_o      (iack_o),
  .take_w      (take_w),
  .rfe_w       (rfe_w),
  .code_w      (code_w),
  .status_q    (status_q),
  .epc_q       (epc_q),
  .cause_q     (cause_q)
);

// File: tb/cp0_exc_unit_tb_top.sv
module cp0_exc_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr_i, pc_i, gpr_wdata_i;
  logic        instr_end_i, ovf_i, undef_i, irq_i;
  logic [31:0] cp0_rdata_o, pc_target_o;
  logic        pc_load_o, iack_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp0_exc_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_i     (instr_i),
    .instr_end_i (instr_end_i),
    .pc_i        (pc_i),
    .ovf_i       (ovf_i),
    .undef_i     (undef_i),
    .irq_i       (irq_i),
    .gpr_wdata_i (gpr_wdata_i),
    .cp0_rdata_o (cp0_rdata_o),
    .pc_load_o   (pc_load_o),
    .pc_target_o (pc_target_o),
    .iack_o      (iack_o)
  );

  localparam logic [31:0] I_NOP  = 32'h0000_0000;
  localparam logic [31:0] I_SYSC = 32'h0000_000C;
  localparam logic [31:0] I_RFE  = {6'b010000, 1'b1, 19'd0, 6'b010000};

  function automatic logic [31:0] i_mfc(logic [4:0] r);
    return {6'b010000, 5'b00000, 5'd2, r, 11'd0};
  endfunction

  function automatic logic [31:0] i_mtc(logic [4:0] r);
    return {6'b010000, 5'b00100, 5'd2, r, 11'd0};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] r, output logic [31:0] v);
    instr_end_i = 1'b0;
    instr_i     = i_mfc(r);
    #1;
    v = cp0_rdata_o;
  endtask

  // One boundary; checks the same-cycle outputs.
  task automatic boundary(string tag, logic [31:0] ins, logic [31:0] pc, logic [31:0] wd,
                          logic exp_load, logic [31:0] exp_tgt, logic exp_ack);
    @(negedge clk);
    instr_i = ins; pc_i = pc; gpr_wdata_i = wd; instr_end_i = 1'b1;
    #1;
    check({tag, " load"}, 32'(pc_load_o), 32'(exp_load));
    if (exp_load) check({tag, " target"}, pc_target_o, exp_tgt);
    check({tag, " iack"}, 32'(iack_o), 32'(exp_ack));
    @(posedge clk);
    #1;
    instr_end_i = 1'b0; ovf_i = 1'b0; undef_i = 1'b0; instr_i = I_NOP;
  endtask

  task automatic expect_regs(string tag, logic [31:0] st, logic [31:0] ca, logic [31:0] ep);
    logic [31:0] v;
    rd(5'd12, v); check({tag, " status"}, v, st);
    rd(5'd13, v); check({tag, " cause"}, v, ca);
    rd(5'd14, v); check({tag, " epc"}, v, ep);
  endtask

  task automatic t_reset();
    expect_regs("R1 reset", 32'hF, 32'h0, 32'h0);
    check("R1 reset load", 32'(pc_load_o), 0);
    check("R1 reset iack", 32'(iack_o), 0);
  endtask

  task automatic t_syscall_and_return();
    boundary("R2 R3 syscall", I_SYSC, 32'h100, 0, 1, 32'h4, 0);
    expect_regs("R2 R3 syscall", 32'hF0, 32'h3, 32'h100);
    boundary("R8 rfe", I_RFE, 32'h4, 0, 1, 32'h100, 0);
    expect_regs("R8 rfe", 32'hF, 32'h3, 32'h100);
  endtask

  task automatic t_overflow_early();
    @(negedge clk); ovf_i = 1'b1; #1;
    check("R6 no strobe load", 32'(pc_load_o), 0);
    @(negedge clk); ovf_i = 1'b0; #1;
    check("R6 no strobe load2", 32'(pc_load_o), 0);
    boundary("R6 R3 held ovf", I_NOP, 32'h200, 0, 1, 32'h4, 0);
    expect_regs("R6 R3 ovf", 32'hF0, 32'h2, 32'h200);
    boundary("R8 rfe ovf", I_RFE, 32'h4, 0, 1, 32'h200, 0);
  endtask

  task automatic t_undef();
    undef_i = 1'b1;
    boundary("R3 undef", I_NOP, 32'h240, 0, 1, 32'h4, 0);
    expect_regs("R3 undef", 32'hF0, 32'h1, 32'h240);
    boundary("R8 rfe undef", I_RFE, 32'h4, 0, 1, 32'h240, 0);
  endtask

  task automatic t_priority_and_irq();
    ovf_i = 1'b1; undef_i = 1'b1; irq_i = 1'b1;
    boundary("R5 all pending", I_SYSC, 32'h300, 0, 1, 32'h4, 0);
    expect_regs("R5 ovf wins", 32'hF0, 32'h2, 32'h300);
    boundary("R9 rfe with irq", I_RFE, 32'h4, 0, 1, 32'h300, 0);
    expect_regs("R9 rfe no take", 32'hF, 32'h2, 32'h300);
    boundary("R7 irq taken", I_NOP, 32'h304, 0, 1, 32'h4, 1);
    expect_regs("R7 irq", 32'hF0, 32'h0, 32'h304);
    boundary("R7 irq masked next", I_NOP, 32'h8, 0, 0, 32'h0, 0);
    irq_i = 1'b0;
    boundary("R8 rfe irq", I_RFE, 32'hC, 0, 1, 32'h304, 0);
  endtask

  task automatic t_masks();
    boundary("R10 mtc status", i_mtc(5'd12), 32'h400, 32'hD, 0, 32'h0, 0);
    ovf_i = 1'b1;
    boundary("R5 ovf masked sysc taken", I_SYSC, 32'h404, 0, 1, 32'h4, 0);
    expect_regs("R5 sysc", 32'hD0, 32'h3, 32'h404);
    boundary("R8 rfe mask", I_RFE, 32'h8, 0, 1, 32'h404, 0);
    boundary("R10 mtc status0", i_mtc(5'd12), 32'h408, 32'h0, 0, 32'h0, 0);
    ovf_i = 1'b1; undef_i = 1'b1; irq_i = 1'b1;
    boundary("R4 all masked", I_SYSC, 32'h40C, 0, 0, 32'h0, 0);
    irq_i = 1'b0;
    expect_regs("R4 unchanged", 32'h0, 32'h3, 32'h404);
    boundary("R10 restore", i_mtc(5'd12), 32'h410, 32'hF, 0, 32'h0, 0);
  endtask

  task automatic t_irq_wait();
    irq_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check("R7 wait iack", 32'(iack_o), 0);
      check("R7 wait load", 32'(pc_load_o), 0);
    end
    boundary("R7 irq boundary", I_NOP, 32'h500, 0, 1, 32'h4, 1);
    @(negedge clk); #1;
    check("R7 iack single", 32'(iack_o), 0);
    irq_i = 1'b0;
    boundary("R8 rfe wait", I_RFE, 32'h8, 0, 1, 32'h500, 0);
  endtask

  task automatic t_transfers();
    logic [31:0] v;
    boundary("R10 mtc epc", i_mtc(5'd14), 32'h600, 32'h1234_5678, 0, 32'h0, 0);
    boundary("R10 mtc cause", i_mtc(5'd13), 32'h604, 32'hFFFF_FFFE, 0, 32'h0, 0);
    boundary("R10 mtc other", i_mtc(5'd5), 32'h608, 32'hDEAD_BEEF, 0, 32'h0, 0);
    expect_regs("R10 writes", 32'hF, 32'h2, 32'h1234_5678);
    rd(5'd5, v);  check("R11 unimpl 5", v, 32'h0);
    rd(5'd15, v); check("R11 unimpl 15", v, 32'h0);
    undef_i = 1'b1;
    boundary("R12 event beats mtc", i_mtc(5'd14), 32'h700, 32'hAAAA_AAAA, 1, 32'h4, 0);
    expect_regs("R12 write dropped", 32'hF0, 32'h1, 32'h700);
    boundary("R8 rfe final", I_RFE, 32'h8, 0, 1, 32'h700, 0);
    expect_regs("R8 final", 32'hF, 32'h1, 32'h700);
  endtask

  initial begin
    rst_n = 1'b0; instr_i = I_NOP; pc_i = '0; gpr_wdata_i = '0;
    instr_end_i = 1'b0; ovf_i = 1'b0; undef_i = 1'b0; irq_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_syscall_and_return();
    t_overflow_early();
    t_undef();
    t_priority_and_irq();
    t_masks();
    t_irq_wait();
    t_transfers();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule